// File: doc/BRIEF.md
# Predicated double-to-single round-to-odd narrowing converter

This block narrows a vector of 64-bit double-precision lanes to single precision in one pass. Every active lane is converted with round-to-odd rounding. Round-to-odd truncates the significand and then sets the result's least significant bit whenever any dropped bit was nonzero. No control-register rounding mode takes part. The 32-bit result sits in the low half of its 64-bit lane, and the high half is cleared.

Lanes that are not active keep the previous destination value in merging mode, and are cleared in zeroing mode. A single mode pin selects between the two.

An operation enters on a valid/ready input handshake, and its result leaves on a valid/ready output handshake one clock later. The input is ready whenever the output register is empty or is being drained in the same cycle. When `out_ready` is low and a result is held, `in_ready` drops, and the held result and flags stay unchanged until they are taken. A 4-bit exception summary comes with every result. It is the OR of the flags raised by the active lanes of that operation.

Top module: `fp64_rto_narrow`

## Requirements
- R1: An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` high after that edge. `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `dst_vec` and `exc_flags` hold.
- R2: Lane e (bits 64e+63..64e) is active exactly when `pred[8e]` is 1. The other seven predicate bits of each group have no effect.
- R3: For a normal input in single range, an active lane's result is the sign, the rebiased exponent and the top 23 fraction bits, with bit 0 ORed with any nonzero discarded bit. The inexact flag is raised when a discarded bit is nonzero. Bits 63..32 of the lane are zero.
- R4: With `zero_mode`=0, an inactive lane equals the same lane of `dst_old`.
- R5: With `zero_mode`=1, an inactive lane is all zeros.
- R6: A finite input with biased exponent 1151 or more gives 0x7F7FFFFF, or 0xFF7FFFFF when negative, and raises overflow and inexact. Biased exponent 1150 with all-ones top fraction is exact.
- R7: Infinities give 0x7F800000 or 0xFF800000. Zeros give 0x00000000 or 0x80000000.
- R8: A NaN gives sign, exponent 0xFF, fraction bit 22 set and fraction bits 21..0 equal to input fraction bits 50..29. When `default_nan`=1 it gives 0x7FC00000 instead. An input with fraction bit 51 clear (signaling) raises invalid.
- R9: A result below the single normal range is shifted to a denormal first and then rounded to odd. If it is inexact, underflow and inexact are both raised. With `flush_zero`=1 such a result, and any double denormal, becomes a signed zero and raises underflow only.
- R10: `exc_flags` bit 0 is inexact, bit 1 underflow, bit 2 overflow and bit 3 invalid. Only active lanes contribute to it.
- R11: After reset `out_valid` is 0, `in_ready` is 1, and `dst_vec` and `exc_flags` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken |
| src_vec | input | VLEN | Double-precision source lanes |
| dst_old | input | VLEN | Previous destination value |
| pred | input | VLEN/8 | Predicate, one bit per byte |
| zero_mode | input | 1 | 1: zeroing, 0: merging |
| flush_zero | input | 1 | Flush tiny results to signed zero |
| default_nan | input | 1 | NaN results use the canonical quiet NaN |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Result taken |
| dst_vec | output | VLEN | New destination vector |
| exc_flags | output | 4 | Exception summary of the active lanes |

## Verification
Every result and its flags are registered once. They are therefore due on the first rising edge after the accepting edge, and they stay there for exactly one cycle when `out_ready` is high. The bench drives an operation on a falling edge, lets it be taken on the next rising edge, and samples `out_valid`, `dst_vec` and `exc_flags` on the following falling edge. The stall scenario holds `out_ready` low for several cycles and checks at each falling edge that the held result does not change and that a second offer is refused. It then releases `out_ready` and checks that the second result appears one edge later.

// File: rtl/fp64_rto_pkg.sv
package fp64_rto_pkg;
  localparam int unsigned FLAG_W  = 4;
  localparam int unsigned FLG_IX  = 0;
  localparam int unsigned FLG_UF  = 1;
  localparam int unsigned FLG_OF  = 2;
  localparam int unsigned FLG_IV  = 3;
  localparam int unsigned LANE_W  = 64;
  localparam int unsigned HALF_W  = 32;
  typedef logic [FLAG_W-1:0] exc_t;
endpackage

// File: rtl/fp64_rto_lane_cvt.sv
module fp64_rto_lane_cvt
  import fp64_rto_pkg::*;
(
  input  logic [LANE_W-1:0] din,
  input  logic              flush_zero,
  input  logic              default_nan,
  output logic [HALF_W-1:0] res,
  output exc_t              flg
);
  localparam logic [10:0] E_MAX  = 11'h7FF;
  localparam logic [10:0] E_OVF  = 11'd1151;
  localparam logic [10:0] E_NRM  = 11'd897;
  localparam logic [10:0] SH_OFS = 11'd926;
  localparam logic [5:0]  SH_CAP = 6'd53;

  logic        sgn;
  logic [10:0] ex;
  logic [51:0] fr;
  logic [52:0] sig;
  logic [10:0] sh;
  logic [5:0]  sh_c;
  logic [75:0] wide;
  logic [22:0] dfrac;
  logic        dsticky;
  logic        nsticky;
  logic [7:0]  ex8;

  assign sgn     = din[63];
  assign ex      = din[62:52];
  assign fr      = din[51:0];
  assign sig     = {1'b1, fr};
  assign sh      = SH_OFS - ex;
  assign sh_c    = (sh > 11'(SH_CAP)) ? SH_CAP : sh[5:0];
  assign wide    = 76'({sig, 53'd0} >> sh_c);
  assign dfrac   = wide[75:53];
  assign dsticky = |wide[52:0];
  assign nsticky = |fr[28:0];
  assign ex8     = ex[7:0] + 8'd128;

  always_comb begin
    res = '0;
    flg = '0;
    if (ex == E_MAX) begin
      if (fr == '0) begin
        res = {sgn, 8'hFF, 23'd0};
      end else begin
        flg[FLG_IV] = ~fr[51];
        res = default_nan ? 32'h7FC0_0000 : {sgn, 8'hFF, 1'b1, fr[50:29]};
      end
    end else if (ex == '0) begin
      if (fr == '0) begin
        res = {sgn, 31'd0};
      end else if (flush_zero) begin
        res = {sgn, 31'd0};
        flg[FLG_UF] = 1'b1;
      end else begin
        res = {sgn, 30'd0, 1'b1};
        flg[FLG_UF] = 1'b1;
        flg[FLG_IX] = 1'b1;
      end
    end else if (ex >= E_OVF) begin
      res = {sgn, 8'hFE, 23'h7F_FFFF};
      flg[FLG_OF] = 1'b1;
      flg[FLG_IX] = 1'b1;
    end else if (ex >= E_NRM) begin
      res = {sgn, ex8, fr[51:30], fr[29] | nsticky};
      flg[FLG_IX] = nsticky;
    end else if (flush_zero) begin
      res = {sgn, 31'd0};
      flg[FLG_UF] = 1'b1;
    end else begin
      res = {sgn, 8'h00, dfrac[22:1], dfrac[0] | dsticky};
      flg[FLG_IX] = dsticky;
      flg[FLG_UF] = dsticky;
    end
  end
endmodule

// File: rtl/fp64_rto_lane_sel.sv
module fp64_rto_lane_sel
  import fp64_rto_pkg::*;
(
  input  logic              active,
  input  logic              zero_mode,
  input  logic [LANE_W-1:0] old_lane,
  input  logic [HALF_W-1:0] cvt_res,
  input  exc_t              cvt_flg,
  output logic [LANE_W-1:0] new_lane,
  output exc_t              lane_flg
);
  always_comb begin
    if (active)         new_lane = {{(LANE_W-HALF_W){1'b0}}, cvt_res};
    else if (zero_mode) new_lane = '0;
    else                new_lane = old_lane;
    lane_flg = active ? cvt_flg : '0;
  end
endmodule

// File: rtl/fp64_rto_narrow.sv
module fp64_rto_narrow
  import fp64_rto_pkg::*;
#(
  parameter int unsigned VLEN = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [VLEN-1:0] src_vec,
  input  logic [VLEN-1:0] dst_old,
  input  logic [VLEN/8-1:0] pred,
  input  logic            zero_mode,
  input  logic            flush_zero,
  input  logic            default_nan,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [VLEN-1:0] dst_vec,
  output exc_t            exc_flags
);
  localparam int unsigned LANES = VLEN / LANE_W;
  localparam int unsigned PBITS = LANE_W / 8;

  logic [LANES-1:0]  act;
  logic              any_act;
  logic [VLEN-1:0]   src_eff;
  logic [VLEN-1:0]   nxt_vec;
  exc_t              lflg [LANES];
  exc_t              nxt_flg;
  logic              unused_pred;

  assign unused_pred = ^pred;

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    logic [HALF_W-1:0] cres;
    exc_t              cflg;
    assign act[e] = pred[e*PBITS];
    fp64_rto_lane_cvt u_cvt (
      .din         (src_eff[e*LANE_W +: LANE_W]),
      .flush_zero  (flush_zero),
      .default_nan (default_nan),
      .res         (cres),
      .flg         (cflg)
    );
    fp64_rto_lane_sel u_sel (
      .active    (act[e]),
      .zero_mode (zero_mode),
      .old_lane  (dst_old[e*LANE_W +: LANE_W]),
      .cvt_res   (cres),
      .cvt_flg   (cflg),
      .new_lane  (nxt_vec[e*LANE_W +: LANE_W]),
      .lane_flg  (lflg[e])
    );
  end

  assign any_act = |act;
  assign src_eff = any_act ? src_vec : '0;

  always_comb begin
    nxt_flg = '0;
    for (int e = 0; e < LANES; e++) nxt_flg = nxt_flg | lflg[e];
  end

  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dst_vec   <= '0;
      exc_flags <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        dst_vec   <= nxt_vec;
        exc_flags <= nxt_flg;
      end
    end
  end
endmodule

// File: rtl/fp64_rto_narrow_chk.sv
module fp64_rto_narrow_chk
  import fp64_rto_pkg::*;
#(
  parameter int unsigned VLEN = 256
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [VLEN-1:0] dst_vec,
  input exc_t            exc_flags
);
  // R1: accepted operation yields a result on the next edge
  a_r1_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  // R1: a stalled result blocks new input
  a_r1_stall_block: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R1: a stalled result is held
  a_r1_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(dst_vec) && $stable(exc_flags));
  // R6: overflow always comes with inexact
  a_r6_ovf_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && exc_flags[FLG_OF] |-> exc_flags[FLG_IX]);
endmodule

bind fp64_rto_narrow fp64_rto_narrow_chk #(.VLEN(VLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .dst_vec   (dst_vec),
  .exc_flags (exc_flags)
);

// File: tb/test_fp64_rto_narrow.sv
`timescale 1ns/1ps
module test_fp64_rto_narrow;
  localparam int unsigned VLEN = 256;
  localparam int unsigned PW   = VLEN / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [VLEN-1:0] src_vec = '0;
  logic [VLEN-1:0] dst_old = '0;
  logic [PW-1:0]   pred = '0;
  logic zero_mode = 1'b0, flush_zero = 1'b0, default_nan = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [VLEN-1:0] dst_vec;
  logic [3:0] exc_flags;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fp64_rto_narrow #(.VLEN(VLEN)) i_fp64_rto_narrow (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src_vec(src_vec), .dst_old(dst_old), .pred(pred), .zero_mode(zero_mode),
    .flush_zero(flush_zero), .default_nan(default_nan), .out_valid(out_valid),
    .out_ready(out_ready), .dst_vec(dst_vec), .exc_flags(exc_flags)
  );

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Offer one operation at a falling edge; sample one edge after acceptance.
  task automatic run_op(input logic [255:0] s, input logic [255:0] o, input logic [31:0] p,
                        input logic zm, input logic fz, input logic dn);
    @(negedge clk);
    src_vec = s; dst_old = o; pred = p;
    zero_mode = zm; flush_zero = fz; default_nan = dn; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 out_valid after accept", {255'd0, out_valid}, 256'd1);
  endtask

  localparam logic [31:0] ALL = 32'h0101_0101;
  localparam logic [255:0] OLD = {64'hAAAA_AAAA_AAAA_AAAA, 64'hBBBB_BBBB_BBBB_BBBB,
                                   64'hCCCC_CCCC_CCCC_CCCC, 64'hDDDD_DDDD_DDDD_DDDD};

  task automatic t_reset;
    chk("R11 reset out_valid", {255'd0, out_valid}, 256'd0);
    chk("R11 reset in_ready", {255'd0, in_ready}, 256'd1);
    chk("R11 reset dst_vec", dst_vec, 256'd0);
    chk("R11 reset flags", {252'd0, exc_flags}, 256'd0);
  endtask

  task automatic t_normal;
    run_op({64'h3FF0_0000_3000_0000, 64'h3FF0_0000_2000_0000,
            64'h3FF0_0000_0040_0000, 64'h3FF0_0000_0000_0000}, OLD, ALL, 0, 0, 0);
    chk("R3 round-to-odd lanes", dst_vec,
        {64'h3F80_0001, 64'h3F80_0001, 64'h3F80_0001, 64'h3F80_0000});
    chk("R10 inexact only", {252'd0, exc_flags}, 256'd1);
    run_op({64'hC000_0000_0000_0000, 64'h3FF0_0000_0000_0000,
            64'h3FF0_0000_0000_0000, 64'h47EF_FFFF_E000_0000}, OLD, ALL, 0, 0, 0);
    chk("R3 R6 exact lanes", dst_vec,
        {64'hC000_0000, 64'h3F80_0000, 64'h3F80_0000, 64'h7F7F_FFFF});
    chk("R3 exact no flags", {252'd0, exc_flags}, 256'd0);
  endtask

  task automatic t_pred;
    // lanes 0 and 2 active; lane 1 predicate group has only non-decoding bits set
    run_op({4{64'h3FF0_0000_0000_0000}}, OLD, 32'h00FE_FE01 | 32'h0001_0000, 0, 0, 0);
    chk("R2 R4 merge", dst_vec,
        {64'hAAAA_AAAA_AAAA_AAAA, 64'h3F80_0000, 64'hCCCC_CCCC_CCCC_CCCC, 64'h3F80_0000});
    run_op({4{64'h3FF0_0000_0000_0000}}, OLD, 32'h0100_FE00, 1, 0, 0);
    chk("R2 R5 zeroing", dst_vec, {64'h3F80_0000, 64'd0, 64'd0, 64'd0});
    run_op({4{64'h7FF0_0000_0000_0001}}, OLD, 32'hFEFE_FEFE, 0, 0, 0);
    chk("R2 R4 no active lane merges", dst_vec, OLD);
    chk("R10 inactive lanes raise nothing", {252'd0, exc_flags}, 256'd0);
    run_op({4{64'h3FF0_0000_0000_0000}}, OLD, 32'h0, 1, 0, 0);
    chk("R5 no active lane zeroes", dst_vec, 256'd0);
  endtask

  task automatic t_ovf;
    run_op({64'h7E37_E43C_8800_759C, 64'hFE37_E43C_8800_759C,
            64'h47F0_0000_0000_0000, 64'h3FF0_0000_0000_0000}, OLD, ALL, 0, 0, 0);
    chk("R6 saturate", dst_vec,
        {64'h7F7F_FFFF, 64'hFF7F_FFFF, 64'h7F7F_FFFF, 64'h3F80_0000});
    chk("R6 R10 overflow inexact", {252'd0, exc_flags}, 256'd5);
  endtask

  task automatic t_special;
    run_op({64'h7FF0_0000_0000_0000, 64'hFFF0_0000_0000_0000,
            64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000}, OLD, ALL, 0, 0, 0);
    chk("R7 inf and zero", dst_vec,
        {64'h7F80_0000, 64'hFF80_0000, 64'h0000_0000, 64'h8000_0000});
    chk("R7 no flags", {252'd0, exc_flags}, 256'd0);
    run_op({64'h7FF8_0000_0000_0000, 64'hFFFA_0000_0000_0000,
            64'h7FF8_0000_0000_0000, 64'h7FF8_0000_0000_0000}, OLD, ALL, 0, 0, 0);
    chk("R8 quiet NaN payload", dst_vec,
        {64'h7FC0_0000, 64'hFFD0_0000, 64'h7FC0_0000, 64'h7FC0_0000});
    chk("R8 quiet NaN no invalid", {252'd0, exc_flags}, 256'd0);
    run_op({64'h7FF4_0000_0000_0000, 64'h7FF0_0000_0000_0001,
            64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000}, OLD, ALL, 0, 0, 0);
    chk("R8 signaling NaN quieted", dst_vec,
        {64'h7FE0_0000, 64'h7FC0_0000, 64'h3F80_0000, 64'h3F80_0000});
    chk("R8 R10 invalid", {252'd0, exc_flags}, 256'd8);
    run_op({64'hFFF4_0000_0000_0000, 64'h3FF0_0000_0000_0000,
            64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000}, OLD, ALL, 0, 0, 1);
    chk("R8 default NaN", dst_vec,
        {64'h7FC0_0000, 64'h3F80_0000, 64'h3F80_0000, 64'h3F80_0000});
  endtask

  task automatic t_tiny;
    run_op({64'h36A0_0000_0000_0000, 64'h3810_0000_0000_0000,
            64'h3800_0000_0000_0000, 64'h3FF0_0000_0000_0000}, OLD, ALL, 0, 0, 0);
    chk("R9 exact denormals", dst_vec,
        {64'h0000_0001, 64'h0080_0000, 64'h0040_0000, 64'h3F80_0000});
    chk("R9 exact no underflow", {252'd0, exc_flags}, 256'd0);
    run_op({64'h3690_0000_0000_0000, 64'h0000_0000_0000_0001,
            64'h8000_0000_0000_0001, 64'h3FF0_0000_0000_0000}, OLD, ALL, 0, 0, 0);
    chk("R9 sticky to odd", dst_vec,
        {64'h0000_0001, 64'h0000_0001, 64'h8000_0001, 64'h3F80_0000});
    chk("R9 underflow inexact", {252'd0, exc_flags}, 256'd3);
    run_op({64'h3800_0000_0000_0000, 64'hB800_0000_0000_0000,
            64'h0000_0000_0000_0001, 64'h3810_0000_0000_0000}, OLD, ALL, 0, 1, 0);
    chk("R9 flush to zero", dst_vec,
        {64'h0000_0000, 64'h8000_0000, 64'h0000_0000, 64'h0080_0000});
    chk("R9 flush underflow only", {252'd0, exc_flags}, 256'd2);
  endtask

  task automatic t_stall;
    logic [255:0] held;
    @(negedge clk);
    out_ready = 1'b0;
    src_vec = {4{64'h3FF0_0000_0000_0000}}; dst_old = OLD; pred = ALL;
    zero_mode = 0; flush_zero = 0; default_nan = 0; in_valid = 1'b1;
    @(negedge clk);
    held = dst_vec;
    chk("R1 stall first result", held, {4{64'h3F80_0000}});
    chk("R1 stall in_ready low", {255'd0, in_ready}, 256'd0);
    src_vec = {4{64'hC000_0000_0000_0000}};
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 stall held", dst_vec, held);
      chk("R1 stall still valid", {255'd0, out_valid}, 256'd1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 second result after release", dst_vec, {4{64'hC000_0000}});
    chk("R1 second valid", {255'd0, out_valid}, 256'd1);
    @(negedge clk);
    chk("R1 drained", {255'd0, out_valid}, 256'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_normal();
    t_pred();
    t_ovf();
    t_special();
    t_tiny();
    t_stall();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule